// File: doc/BRIEF.md
# Streamed Block SAD Accumulation Unit

This unit reduces a 16x16 block of 8-bit unsigned pixel pairs to one scalar: the sum of absolute differences between the two blocks, the basic cost figure used when candidate blocks are matched during motion estimation. A caller pulses `start` and then streams the block one row per cycle. Each row carries 16 pixels of block A and the matching 16 pixels of block B on two 128-bit buses. The unit raises `done` for one cycle when `result` holds the finished sum.

Each row passes through two register stages. The first stage records, for each lane, whether the A pixel is smaller than the B pixel. The second stage forms each lane's difference by adding the larger pixel, the bitwise inverse of the smaller one and one. This needs no subtract-and-negate step. The second stage then compresses the 16 terms with a chain of 3:2 carry-save adders into a sum vector and a carry vector, and registers both. A final adder folds the two vectors into the running accumulator. An internal down-counter counts the rows still expected in the block. It gates row acceptance, so no outside loop control is needed.

Top module: `sad_block_unit`

## Requirements
- R1: After a synchronous reset, `done` is 0 and `result` is 0.
- R2: When `done` is high, `result` equals the sum over all 256 accepted pixel pairs of |A - B|. Pixel pair i of a row sits on bits [8i+7:8i] of `row_a` and `row_b`, for i in 0..15.
- R3: When rows arrive back to back, `done` is high in the 19th cycle, counting the cycle in which the first row is presented as cycle 1.
- R4: A cycle in which `row_valid` is low during a block contributes nothing. The block then finishes as many cycles later as there were such idle cycles.
- R5: A block accepts exactly 16 rows. A row presented with `row_valid` high after the 16th row has been accepted does not change `result`.
- R6: `done` is high for exactly one cycle per block and is never high on two consecutive cycles.
- R7: A `start` pulse that arrives while a block is in progress, up to and including the cycle before `done` is high, is ignored. The block completes with its own result.
- R8: A `start` pulse in the cycle in which `done` is high is accepted and opens a new block.
- R9: In the cycle after an accepted `start`, `result` reads 0.
- R10: Two identical blocks give 0. A block of all 0 against a block of all 255 gives 65280, the largest value, and it does not wrap.
- R11: Rows presented with `row_valid` high while no block has been started are ignored. `done` stays 0 and `result` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Opens a block and clears the accumulator when no block is in progress |
| row_valid | input | 1 | Marks the row buses as carrying a row |
| row_a | input | 128 | 16 pixels of block A, lane i on bits [8i+7:8i] |
| row_b | input | 128 | 16 pixels of block B, same lane layout |
| result | output | 16 | Accumulated sum of absolute differences |
| done | output | 1 | One-cycle pulse; `result` holds the finished block sum |

## Verification
Two events can land in the same cycle: the completion of one block, when the final accumulate writes the sum and `done` rises, and the opening of the next block by `start`. The bench provokes this by raising `start` in the very cycle in which it sees `done` high. It also raises `start` in the cycle just before, and in the middle of a row stream. A behavioural model follows every clock edge. It expects the in-progress starts to be ignored and the start in the `done` cycle to be taken, with the finished sum still visible for that one cycle and `result` reading zero in the next.

// File: rtl/sad_pkg.sv
package sad_pkg;

    localparam int PIX_W  = 8;
    localparam int LANES  = 16;
    localparam int ROWS   = 16;
    localparam int ACC_W  = 16;
    localparam int ROW_W  = PIX_W * LANES;
    localparam int SUM_W  = PIX_W + $clog2(LANES);
    localparam int CNT_W  = $clog2(ROWS);

    typedef logic [PIX_W-1:0] pix_t;
    typedef logic [SUM_W-1:0] psum_t;

    // one lane after the compare stage: order flag and both raw pixels
    typedef struct packed {
        logic a_lt_b;
        pix_t pa;
        pix_t pb;
    } cmp_lane_t;

    // redundant (carry-save) form of a partial sum
    typedef struct packed {
        psum_t s;
        psum_t c;
    } csa_pair_t;

    // 3:2 compressor on whole vectors
    function automatic csa_pair_t csa3(input psum_t x, input psum_t y, input psum_t z);
        csa_pair_t r;
        r.s = x ^ y ^ z;
        r.c = ((x & y) | (x & z) | (y & z)) << 1;
        return r;
    endfunction

    // larger + ~smaller + 1, modulo 2^PIX_W, equals the absolute difference
    function automatic pix_t lane_term(input cmp_lane_t l);
        pix_t big;
        pix_t inv;
        big = l.a_lt_b ? l.pb : l.pa;
        inv = l.a_lt_b ? ~l.pa : ~l.pb;
        return pix_t'(big + inv + pix_t'(1));
    endfunction

endpackage

// File: rtl/sad_row_loader.sv
module sad_row_loader
    import sad_pkg::*;
#(
    parameter int N_ROWS = ROWS,
    localparam int CW    = $clog2(N_ROWS)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic row_valid,
    input  logic blk_fin,
    output logic start_ok,
    output logic row_fire,
    output logic row_last
);

    logic          active_q;
    logic          feeding_q;
    logic [CW-1:0] left_q;

    assign start_ok = start & ~active_q;
    assign row_fire = feeding_q & row_valid;
    assign row_last = row_fire & (left_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q  <= 1'b0;
            feeding_q <= 1'b0;
            left_q    <= '0;
        end else if (start_ok) begin
            active_q  <= 1'b1;
            feeding_q <= 1'b1;
            left_q    <= CW'(N_ROWS - 1);
        end else begin
            if (row_fire) begin
                if (left_q == '0) feeding_q <= 1'b0;
                else              left_q    <= left_q - 1'b1;
            end
            if (blk_fin) active_q <= 1'b0;
        end
    end

    // R7: a start during the drain phase does not reopen row intake
    p_start_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (active_q && !feeding_q && start) |=> !feeding_q);

    // R5: intake closes right after the final row
    p_intake_closes_r5: assert property (@(posedge clk) disable iff (rst)
        row_last |=> !feeding_q);

    // R11: no row is taken outside an open block
    p_idle_no_rows_r11: assert property (@(posedge clk) disable iff (rst)
        row_fire |-> active_q);

endmodule

// File: rtl/sad_cmp_stage.sv
module sad_cmp_stage
    import sad_pkg::*;
#(
    parameter int N_LANES = LANES,
    localparam int BUS_W  = N_LANES * PIX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic [BUS_W-1:0] bus_a,
    input  logic [BUS_W-1:0] bus_b,
    output logic             out_valid,
    output logic             out_last,
    output cmp_lane_t        lane_q [N_LANES]
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_last  <= in_last;
        end
    end

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        pix_t a_w;
        pix_t b_w;
        assign a_w = bus_a[g*PIX_W +: PIX_W];
        assign b_w = bus_b[g*PIX_W +: PIX_W];

        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q[g] <= '0;
            end else if (in_valid) begin
                lane_q[g].a_lt_b <= (a_w < b_w);
                lane_q[g].pa     <= a_w;
                lane_q[g].pb     <= b_w;
            end
        end
    end

    // R4: a row is forwarded only for a row that was accepted
    p_fwd_only_valid_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

endmodule

// File: rtl/sad_reduce_acc.sv
module sad_reduce_acc
    import sad_pkg::*;
#(
    parameter int N_LANES = LANES,
    parameter int AW      = ACC_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            in_valid,
    input  logic            in_last,
    input  cmp_lane_t       lane_q [N_LANES],
    output logic [AW-1:0]   acc_q,
    output logic            blk_fin,
    output logic            done_q
);

    pix_t      term_w [N_LANES];
    csa_pair_t chain_w [N_LANES+1];
    csa_pair_t red_q;
    logic      rv_q;
    logic      rl_q;

    for (genvar g = 0; g < N_LANES; g++) begin : g_term
        assign term_w[g] = lane_term(lane_q[g]);
    end

    // carry-save chain: each level folds one lane term into (s, c)
    assign chain_w[0] = '0;
    for (genvar g = 0; g < N_LANES; g++) begin : g_csa
        assign chain_w[g+1] = csa3(chain_w[g].s, chain_w[g].c, psum_t'(term_w[g]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            red_q <= '0;
            rv_q  <= 1'b0;
            rl_q  <= 1'b0;
        end else begin
            rv_q <= in_valid;
            rl_q <= in_valid & in_last;
            if (in_valid) red_q <= chain_w[N_LANES];
        end
    end

    assign blk_fin = rv_q & rl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= blk_fin;
            if (clear)      acc_q <= '0;
            else if (rv_q)  acc_q <= acc_q + AW'(red_q.s) + AW'(red_q.c);
        end
    end

    // R2: accumulation never wraps for in-range blocks
    p_no_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (rv_q && !clear) |=> acc_q >= $past(acc_q));

    // R6: done is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R9: an accepted start empties the accumulator
    p_clear_zero_r9: assert property (@(posedge clk) disable iff (rst)
        clear |=> acc_q == '0);

endmodule

// File: rtl/sad_block_unit.sv
module sad_block_unit
    import sad_pkg::*;
#(
    parameter int N_LANES = LANES,
    parameter int N_ROWS  = ROWS,
    parameter int AW      = ACC_W,
    localparam int BUS_W  = N_LANES * PIX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             row_valid,
    input  logic [BUS_W-1:0] row_a,
    input  logic [BUS_W-1:0] row_b,
    output logic [AW-1:0]    result,
    output logic             done
);

    logic      start_ok;
    logic      row_fire;
    logic      row_last;
    logic      blk_fin;
    logic      cv;
    logic      cl;
    cmp_lane_t lanes [N_LANES];

    sad_row_loader #(.N_ROWS(N_ROWS)) loader_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .row_valid (row_valid),
        .blk_fin   (blk_fin),
        .start_ok  (start_ok),
        .row_fire  (row_fire),
        .row_last  (row_last)
    );

    sad_cmp_stage #(.N_LANES(N_LANES)) cmp_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (row_fire),
        .in_last   (row_last),
        .bus_a     (row_a),
        .bus_b     (row_b),
        .out_valid (cv),
        .out_last  (cl),
        .lane_q    (lanes)
    );

    sad_reduce_acc #(.N_LANES(N_LANES), .AW(AW)) red_i (
        .clk      (clk),
        .rst      (rst),
        .clear    (start_ok),
        .in_valid (cv),
        .in_last  (cl),
        .lane_q   (lanes),
        .acc_q    (result),
        .blk_fin  (blk_fin),
        .done_q   (done)
    );

    // R3: done follows the final row by exactly three register stages
    p_done_latency_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(row_last, 3));

    // R8: a start in the done cycle is taken
    p_start_on_done_r8: assert property (@(posedge clk) disable iff (rst)
        (done && start) |-> start_ok);

endmodule

// File: tb/sad_block_unit_tb_top.sv
module sad_block_unit_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         row_valid = 1'b0;
    logic [127:0] row_a = '0;
    logic [127:0] row_b = '0;
    logic [15:0]  result;
    logic         done;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    string cur_tag = "R1";

    always #4 clk = ~clk;   // 125 MHz

    sad_block_unit dut_i (
        .clk(clk), .rst(rst), .start(start), .row_valid(row_valid),
        .row_a(row_a), .row_b(row_b), .result(result), .done(done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int row_sad(input logic [127:0] a, input logic [127:0] b);
        int s = 0;
        for (int i = 0; i < 16; i++) begin
            int x = int'(a[i*8 +: 8]);
            int y = int'(b[i*8 +: 8]);
            s += (x > y) ? x - y : y - x;
        end
        return s;
    endfunction

    // behavioural reference, advanced on every rising edge
    bit m_active = 0;
    int m_left = 0;
    int m_sum = 0;
    int m_done_edge = -1;
    bit exp_done = 0;
    bit exp_zero = 0;
    int exp_result = 0;
    bit m_take;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_active = 0; m_left = 0; m_sum = 0; m_done_edge = -1;
            exp_done = 0; exp_zero = 0; exp_result = 0;
        end else begin
            m_take = start && !m_active;
            exp_zero = 0;
            if (m_take) begin
                m_active = 1; m_left = 16; m_sum = 0; exp_zero = 1;
            end else if (m_active && m_left > 0 && row_valid) begin
                m_sum += row_sad(row_a, row_b);
                m_left--;
                if (m_left == 0) m_done_edge = cyc + 2;
            end
            exp_done = (cyc == m_done_edge);
            if (exp_done) begin
                m_active = 0;
                exp_result = m_sum;
            end
        end
    end

    // compare against the model on every clock, away from the edge
    always @(negedge clk) begin
        if (!rst) begin
            check(done === exp_done, {cur_tag, "/R6 done"}, int'(done), int'(exp_done));
            if (exp_done)
                check(result === 16'(exp_result), {cur_tag, "/R2 result"}, int'(result), exp_result);
            if (exp_zero)
                check(result === 16'd0, {cur_tag, "/R9 cleared"}, int'(result), 0);
        end
    end

    // mode 0 random, 1 identical, 2 zeros vs 255
    task automatic run_block(input int mode, input bit do_start, input bit gaps,
                             input int mid_start, input int extra,
                             output int lat, output int res);
        logic [127:0] ra, rb;
        lat = 0;
        if (do_start) begin
            @(negedge clk); start = 1'b1;
        end
        @(negedge clk); start = 1'b0;
        for (int r = 0; r < 16; r++) begin
            if (gaps && $urandom_range(0, 2) == 0) begin
                row_valid = 1'b0;
                row_a = {4{$urandom}};
                lat++;
                @(negedge clk);
            end
            for (int w = 0; w < 4; w++) begin
                ra[w*32 +: 32] = $urandom;
                rb[w*32 +: 32] = $urandom;
            end
            if (mode == 1) rb = ra;
            if (mode == 2) begin ra = '0; rb = {128{1'b1}}; end
            row_valid = 1'b1; row_a = ra; row_b = rb;
            start = (r == mid_start);
            lat++;
            @(negedge clk);
            start = 1'b0;
        end
        for (int e = 0; e < extra; e++) begin
            row_a = {4{$urandom}}; row_b = {4{$urandom}};
            lat++;
            @(negedge clk);
        end
        row_valid = 1'b0;
        lat++;
        for (int g = 0; g < 40 && done !== 1'b1; g++) begin
            @(negedge clk);
            lat++;
        end
        res = int'(result);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int lat, res;
        repeat (3) @(negedge clk);
        cur_tag = "R1";
        check(done === 1'b0, "R1 done after reset", int'(done), 0);
        check(result === 16'd0, "R1 result after reset", int'(result), 0);
        rst = 1'b0;

        // R11: rows with no block open
        cur_tag = "R11";
        row_valid = 1'b1; row_a = {4{$urandom}}; row_b = {4{$urandom}};
        repeat (5) @(negedge clk);
        row_valid = 1'b0;
        check(done === 1'b0, "R11 no done while idle", int'(done), 0);
        check(result === 16'd0, "R11 result untouched", int'(result), 0);

        // R3 latency with back-to-back rows
        cur_tag = "R3";
        run_block(0, 1, 0, -1, 0, lat, res);
        check(lat == 19, "R3 latency", lat, 19);

        // R10 corner blocks
        cur_tag = "R10";
        run_block(1, 1, 0, -1, 0, lat, res);
        check(res == 0, "R10 identical blocks", res, 0);
        run_block(2, 1, 0, -1, 0, lat, res);
        check(res == 65280, "R10 zeros vs 255", res, 65280);

        // R4 idle gaps inside the stream
        cur_tag = "R4";
        for (int k = 0; k < 4; k++) run_block(0, 1, 1, -1, 0, lat, res);

        // R5 rows after the sixteenth are ignored
        cur_tag = "R5";
        run_block(2, 1, 0, -1, 2, lat, res);
        check(res == 65280, "R5 extra rows ignored", res, 65280);

        // R7 start in mid stream and in the last in-progress cycle
        cur_tag = "R7";
        run_block(0, 1, 0, 6, 0, lat, res);
        check(lat == 19, "R7 mid-stream start ignored", lat, 19);
        fork
            run_block(0, 1, 0, -1, 0, lat, res);
            begin
                repeat (19) @(negedge clk);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join
        check(done === 1'b1, "R7 block completed", int'(done), 1);

        // R8 start in the done cycle opens a new block
        cur_tag = "R8";
        run_block(0, 1, 0, -1, 0, lat, res);
        start = 1'b1;
        run_block(1, 0, 0, -1, 0, lat, res);
        check(lat == 19, "R8 chained block latency", lat, 19);
        check(res == 0, "R8 chained block result", res, 0);

        cur_tag = "R2";
        for (int k = 0; k < 6; k++) run_block(0, 1, k[0], -1, 0, lat, res);
        repeat (4) @(negedge clk);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule